// File: doc/BRIEF.md
# Dependency-limited dot-product accumulator

The block computes the dot product of two signed vectors held in two on-block memories. A write port loads element pairs while the block is idle. A single-cycle `start_i` then launches a run. The run walks through every element pair. Each pair is read, multiplied in a fixed-latency pipelined multiplier, and added into a running sum in a fixed-latency pipelined adder. The adder's output is fed back to its own operand input through a multiplexer. On the first iteration the multiplexer supplies zero, and on every later iteration it supplies the previous sum.

Each addition depends on the previous sum, so a new iteration can enter the adder only once that sum has come out of the adder. The controller therefore issues one iteration every `ADD_LAT` cycles, which is 7 by default. Reads and multiplies for the next iteration overlap the addition still in flight. With 1024 elements, a 2-cycle read, a 3-cycle multiply, a 7-cycle add and 1 writeback cycle, one iteration spans 13 cycles. Run one after another without overlap, the iterations would take 13312 cycles. The overlapped run finishes 7 × 1023 + 13 − 1 = 7173 cycles after start. The final sum is then written to a result register, and `done_o` pulses.

Top module: `dotacc`

## Requirements
- R1: At the end of a run, `result_o` equals the sum of `a[i]*b[i]` over all N = 1024 addresses. The products are signed 16 × 16 and are sign-extended. The sum is kept in ACC_W = 48 bits two's complement and wraps on overflow.
- R2: When `wr_en_i` is high at a rising edge, the pair (`wr_a_i`, `wr_b_i`) is stored at `wr_addr_i`. A later write to the same address replaces the earlier pair for all following runs.
- R3: `done_o` is high in the cycle that follows exactly II·(N−1) + 12 = 7173 rising edges after the edge that sampled `start_i` high, where 12 is the 13-cycle iteration latency minus one.
- R4: Iterations enter the adder at most once every II = ADD_LAT = 7 cycles. Each one after the first consumes the previous sum in the same cycle that the sum leaves the adder.
- R5: The first iteration of every run adds into zero. A second run over unchanged memories produces the same result as the first and does not include the earlier total.
- R6: `done_o` is a one-cycle pulse, exactly one per run.
- R7: `result_o` changes only in a cycle where `done_o` is high and holds its value at all other times.
- R8: A `start_i` pulse that arrives while a run is in progress, including its drain, is ignored. The done time and the result of the ongoing run are unaffected.
- R9: While `rst_ni` is low, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a run when the block is idle |
| wr_en_i | input | 1 | Memory write strobe |
| wr_addr_i | input | 10 | Element address for the write |
| wr_a_i | input | 16 | Signed element of vector a |
| wr_b_i | input | 16 | Signed element of vector b |
| done_o | output | 1 | One-cycle pulse when the result is written |
| result_o | output | 48 | Dot-product result register |

## Verification
The assertions assume that the memories are not written while a run is in progress. Under that assumption, the operand pairs of a run are the ones loaded beforehand. The stimulus only loads vectors between runs, and it waits for `done_o` before each new write sequence. `start_i` may arrive at any time. The bench deliberately pulses it in the middle of a run to show that it is ignored. It also compares `done_o` and `result_o` against a behavioural cycle counter and a reference sum on every clock.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } iter_tag_t;

  localparam int unsigned TAG_W = 3;
endpackage

// File: rtl/dotacc_delay.sv
module dotacc_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_shift
      logic [W-1:0] sh_q [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)     sh_q[s] <= '0;
          else if (s == 0) sh_q[s] <= d_i;
          else             sh_q[s] <= sh_q[(s == 0) ? 0 : s-1];
        end
      end
      assign q_o = sh_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dotacc_vmem.sv
module dotacc_vmem #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic signed [DW-1:0] wr_a_i,
  input  logic signed [DW-1:0] wr_b_i,
  input  logic                 rd_en_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic signed [DW-1:0] rd_a_o,
  output logic signed [DW-1:0] rd_b_o
);
  logic [DW-1:0] ram_a [DEPTH];
  logic [DW-1:0] ram_b [DEPTH];
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      ram_a[wr_addr_i] <= wr_a_i;
      ram_b[wr_addr_i] <= wr_b_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (rd_en_i) addr_q <= rd_addr_i;
  end

  // registered address, array read in the following cycle
  assign rd_a_o = ram_a[addr_q];
  assign rd_b_o = ram_b[addr_q];
endmodule

// File: rtl/dotacc_ctrl.sv
module dotacc_ctrl #(
  parameter int unsigned N  = 1024,
  parameter int unsigned II = 7,
  localparam int unsigned AW = $clog2(N),
  localparam int unsigned PW = (II > 1) ? $clog2(II) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fin_i,
  output logic          issue_o,
  output logic          first_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);
  logic          run_q, iss_q;
  logic [PW-1:0] ph_q;
  logic [AW-1:0] idx_q;

  assign issue_o = iss_q && (ph_q == '0);
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == AW'(N-1));
  assign addr_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      iss_q <= 1'b0;
      ph_q  <= '0;
      idx_q <= '0;
    end else if (start_i && !run_q) begin
      run_q <= 1'b1;
      iss_q <= 1'b1;
      ph_q  <= '0;
      idx_q <= '0;
    end else begin
      if (iss_q) begin
        ph_q <= (ph_q == PW'(II-1)) ? '0 : ph_q + 1'b1;
        if (issue_o) begin
          if (last_o) iss_q <= 1'b0;
          else        idx_q <= idx_q + 1'b1;
        end
      end
      if (fin_i) run_q <= 1'b0;
    end
  end

  // R8: no issue slot outside a run
  assert_issue_in_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> run_q);
endmodule

// File: rtl/dotacc_mul.sv
module dotacc_mul
  import dotacc_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 3,
  localparam int unsigned PW = 2*DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  iter_tag_t            tag_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output iter_tag_t            tag_o,
  output logic signed [PW-1:0] prod_o
);
  iter_tag_t            t1_q;
  logic signed [PW-1:0] p1_q;
  logic [TAG_W+PW-1:0]  tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_q <= '0;
      p1_q <= '0;
    end else begin
      t1_q <= tag_i;
      p1_q <= a_i * b_i;
    end
  end

  // pad to the fixed multiply latency
  dotacc_delay #(.W(TAG_W+PW), .DEPTH(LAT-1)) u_pad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({t1_q, p1_q}),
    .q_o    (tail)
  );

  assign tag_o  = iter_tag_t'(tail[TAG_W+PW-1:PW]);
  assign prod_o = tail[PW-1:0];
endmodule

// File: rtl/dotacc_add.sv
module dotacc_add
  import dotacc_pkg::*;
#(
  parameter int unsigned W   = 48,
  parameter int unsigned LAT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  iter_tag_t           tag_i,
  input  logic signed [W-1:0] x_i,
  output iter_tag_t           tag_o,
  output logic signed [W-1:0] sum_o
);
  iter_tag_t           t1_q;
  logic [W-1:0]        s1_q;
  logic [W-1:0]        fb;
  logic [TAG_W+W-1:0]  tail;

  // loop-carried operand: zero opens a run, the previous sum continues it
  assign fb = tag_i.first ? '0 : sum_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_q <= '0;
      s1_q <= '0;
    end else begin
      t1_q <= tag_i;
      s1_q <= x_i + fb;
    end
  end

  dotacc_delay #(.W(TAG_W+W), .DEPTH(LAT-1)) u_pad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({t1_q, s1_q}),
    .q_o    (tail)
  );

  assign tag_o = iter_tag_t'(tail[TAG_W+W-1:W]);
  assign sum_o = tail[W-1:0];

  // R4: a continuing iteration meets its predecessor's sum at the adder output
  assert_dep_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i.vld && !tag_i.first) |-> tag_o.vld);

  // R5: a run's opening add never overlaps a sum still in flight
  assert_no_stale_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i.vld && tag_i.first) |-> !tag_o.vld);
endmodule

// File: rtl/dotacc.sv
module dotacc
  import dotacc_pkg::*;
#(
  parameter int unsigned N       = 1024,
  parameter int unsigned DW      = 16,
  parameter int unsigned ACC_W   = 48,
  parameter int unsigned MUL_LAT = 3,
  parameter int unsigned ADD_LAT = 7,
  localparam int unsigned AW     = $clog2(N),
  localparam int unsigned PW     = 2*DW,
  localparam int unsigned II     = ADD_LAT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic signed [DW-1:0] wr_a_i,
  input  logic signed [DW-1:0] wr_b_i,
  output logic                 done_o,
  output logic [ACC_W-1:0]     result_o
);
  logic                    issue, first, last, fin;
  logic [AW-1:0]           rd_addr;
  logic signed [DW-1:0]    rd_a, rd_b;
  iter_tag_t               rd_tag_q, mul_tag, add_tag;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_x, sum;
  logic                    done_q;
  logic [ACC_W-1:0]        res_q;

  dotacc_ctrl #(.N(N), .II(II)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .fin_i   (fin),
    .issue_o (issue),
    .first_o (first),
    .last_o  (last),
    .addr_o  (rd_addr)
  );

  dotacc_vmem #(.DW(DW), .DEPTH(N)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_a_i    (wr_a_i),
    .wr_b_i    (wr_b_i),
    .rd_en_i   (issue),
    .rd_addr_i (rd_addr),
    .rd_a_o    (rd_a),
    .rd_b_o    (rd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_tag_q <= '0;
    else         rd_tag_q <= '{vld: issue, first: first, last: last};
  end

  dotacc_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (rd_tag_q),
    .a_i    (rd_a),
    .b_i    (rd_b),
    .tag_o  (mul_tag),
    .prod_o (prod)
  );

  assign prod_x = {{(ACC_W-PW){prod[PW-1]}}, prod};

  dotacc_add #(.W(ACC_W), .LAT(ADD_LAT)) u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (mul_tag),
    .x_i    (prod_x),
    .tag_o  (add_tag),
    .sum_o  (sum)
  );

  assign fin = add_tag.vld && add_tag.last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) res_q <= sum;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/dotacc_bench.sv
module dotacc_bench;
  localparam int CLK_P   = 10;
  localparam int N       = 1024;
  localparam int DW      = 16;
  localparam int ACC_W   = 48;
  localparam int II      = 7;
  localparam int ITER    = 2 + 3 + 7 + 1;
  localparam int DONE_LT = II*(N-1) + ITER - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [9:0]        wr_addr_i = '0;
  logic signed [15:0] wr_a_i = '0, wr_b_i = '0;
  logic              done_o;
  logic [ACC_W-1:0]  result_o;

  int checks = 0, errors = 0;
  logic signed [DW-1:0] ma [N];
  logic signed [DW-1:0] mb [N];

  // behavioural model state
  bit               m_busy = 0, m_done = 0;
  int               m_cnt = 0;
  logic [ACC_W-1:0] m_res = '0, m_pend = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dotacc u_dotacc (
    .clk_i, .rst_ni, .start_i, .wr_en_i, .wr_addr_i,
    .wr_a_i, .wr_b_i, .done_o, .result_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] ref_sum();
    longint acc = 0;
    for (int i = 0; i < N; i++) acc += longint'(ma[i]) * longint'(mb[i]);
    return acc[ACC_W-1:0];
  endfunction

  // cycle-level model: start accepted only when idle, done after DONE_LT edges
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == DONE_LT) begin
          m_done = 1; m_res = m_pend; m_busy = 0;
        end
      end else if (start_i) begin
        m_busy = 1; m_cnt = 0; m_pend = ref_sum();
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(done_o == m_done, "R3/R6 done vs model", longint'(done_o), longint'(m_done));
      chk(result_o == m_res, "R1/R7 result vs model", longint'(result_o), longint'(m_res));
    end
  end

  task automatic wr(input int addr, input int a, input int b);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 10'(addr); wr_a_i = 16'(a); wr_b_i = 16'(b);
    ma[addr] = 16'(a); mb[addr] = 16'(b);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic load(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: wr(i, (i*37) % 2001 - 1000, (i*113) % 4001 - 2000);
        1: wr(i, (i % 2) ? 32767 : -32768, -32768);
        default: wr(i, (i % 3) - 1, 32767 - i);
      endcase
    end
  endtask

  task automatic run(input bit poke, input string tag);
    int k = 0;
    logic [ACC_W-1:0] exp_v, held;
    exp_v = ref_sum();
    @(negedge clk_i); start_i = 1;
    forever begin
      @(negedge clk_i);
      k++;
      start_i = (poke && k == 100) ? 1'b1 : 1'b0;  // R8 mid-run start
      if (done_o || k > 20000) break;
    end
    chk(k-1 == DONE_LT, {"R3 latency ", tag}, k-1, DONE_LT);
    chk((k-1-(ITER-1)) == II*(N-1), {"R4 issue interval ", tag}, (k-1-(ITER-1))/(N-1), II);
    chk(result_o == exp_v, {"R1 sum ", tag}, longint'(result_o), longint'(exp_v));
    if (poke) chk(result_o == exp_v && k-1 == DONE_LT, "R8 start ignored", k-1, DONE_LT);
    held = result_o;
    @(negedge clk_i);
    chk(done_o == 0, {"R6 pulse ", tag}, longint'(done_o), 0);
    repeat (10) @(negedge clk_i);
    chk(result_o == held, {"R7 hold ", tag}, longint'(result_o), longint'(held));
  endtask

  initial begin
    logic [ACC_W-1:0] r_first;
    repeat (3) @(negedge clk_i);
    chk(done_o == 0, "R9 reset done", longint'(done_o), 0);
    chk(result_o == 0, "R9 reset result", longint'(result_o), 0);
    rst_ni = 1;
    load(0);
    run(0, "mixed");
    r_first = result_o;
    run(0, "rerun");
    chk(result_o == r_first, "R5 rerun starts from zero", longint'(result_o), longint'(r_first));
    load(1);
    run(1, "extremes");
    load(0);
    wr(5, 100, 200);
    wr(5, -7, 9);
    run(0, "overwrite");
    chk(ma[5] == -7 && result_o == ref_sum(), "R2 last write wins",
        longint'(result_o), longint'(ref_sum()));
    load(2);
    run(0, "ramp");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P*190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule